// File: doc/BRIEF.md
# Cascadable Magnitude Comparator

This block compares two unsigned words, A and B, and reports the outcome on three active-high outputs: A greater than B, A equal to B, and A less than B. The word is cut into 4-bit slices. Each slice is handled by one comparator stage. A stage first tests its own pair of nibbles. It forwards the result arriving from the stage below only when its own nibbles are equal.

The top level chains `WIDTH/SLICE` stages, which by default gives two stages and an 8-bit comparison. The least-significant stage takes its ordering inputs from three cascade pins. To compare the word on its own, drive those pins with equal high and the other two low. To extend the comparison further, wire in the outputs of another comparator that covers lower-order bits.

The block is purely combinational, so it has no states and no transitions. Results appear in the same cycle the operands change.

Top module: `mag_cmp_chain`

## Requirements
- R1: With cascade inputs gt/eq/lt = 0/1/0, `a_gt_b` is high exactly when the unsigned value of `a_word` exceeds that of `b_word`.
- R2: With cascade inputs gt/eq/lt = 0/1/0, `a_eq_b` is high exactly when the two words are equal.
- R3: With cascade inputs gt/eq/lt = 0/1/0, `a_lt_b` is high exactly when `a_word` is below `b_word`.
- R4: Whenever exactly one cascade input is high, exactly one of the three outputs is high.
- R5: When the most-significant nibbles differ, that nibble pair alone sets the result, and the lower nibbles and the cascade inputs have no effect.
- R6: When the two full words are equal, the three outputs equal the three cascade inputs bit for bit, including the combinations 000 and 111.
- R7: Bit 0 is the least and bit WIDTH-1 the most significant bit of each word. A difference in bit 7 outweighs every lower bit.
- R8: When the upper nibbles are equal and the lower nibbles differ, the lower nibbles decide the result and the cascade inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_word | input | WIDTH (8) | Operand A, unsigned |
| b_word | input | WIDTH (8) | Operand B, unsigned |
| cin_gt | input | 1 | Greater result from a lower-order comparator |
| cin_eq | input | 1 | Equal result from a lower-order comparator (tie high when unused) |
| cin_lt | input | 1 | Less result from a lower-order comparator |
| a_gt_b | output | 1 | A greater than B |
| a_eq_b | output | 1 | A equal to B |
| a_lt_b | output | 1 | A less than B |

## Verification
Two decisions are made in the same evaluation: the upper stage's local decision and the lower stage's local decision, and they can point in opposite directions. Vectors such as A=0x2A, B=0x35 (upper nibble less, lower nibble greater) provoke this. The result must follow the upper nibble. An exhaustive sweep of all operand pairs is checked against a behavioural ordering of the whole word. Directed vectors with equal words and unusual cascade patterns check that the cascade inputs pass through, and that they are ignored whenever any nibble differs.

// File: rtl/mag_cmp_pkg.sv
package mag_cmp_pkg;

    typedef struct packed {
        logic gt;
        logic eq;
        logic lt;
    } order_t;

endpackage

// File: rtl/nib_match.sv
module nib_match #(
    parameter int SLICE = 4
) (
    input  logic [SLICE-1:0] lhs,
    input  logic [SLICE-1:0] rhs,
    output logic             same
);
    logic [SLICE-1:0] bit_same;

    genvar gi;
    generate
        for (gi = 0; gi < SLICE; gi++) begin : g_xnor
            assign bit_same[gi] = ~(lhs[gi] ^ rhs[gi]);
        end
    endgenerate

    assign same = &bit_same;
endmodule

// File: rtl/nib_rank.sv
module nib_rank #(
    parameter int SLICE = 4
) (
    input  logic [SLICE-1:0] lhs,
    input  logic [SLICE-1:0] rhs,
    output logic             lhs_above
);
    logic [SLICE:0] tie_above;
    logic [SLICE-1:0] win_here;

    assign tie_above[SLICE] = 1'b1;

    genvar gi;
    generate
        for (gi = SLICE - 1; gi >= 0; gi--) begin : g_rank
            assign win_here[gi]  = tie_above[gi+1] & lhs[gi] & ~rhs[gi];
            assign tie_above[gi] = tie_above[gi+1] & ~(lhs[gi] ^ rhs[gi]);
        end
    endgenerate

    assign lhs_above = |win_here;
endmodule

// File: rtl/cmp_stage.sv
module cmp_stage
    import mag_cmp_pkg::*;
#(
    parameter int SLICE = 4
) (
    input  logic [SLICE-1:0] a_nib,
    input  logic [SLICE-1:0] b_nib,
    input  order_t           from_low,
    output order_t           to_high
);
    logic nib_same;
    logic nib_above;

    nib_match #(.SLICE(SLICE)) u_match (
        .lhs  (a_nib),
        .rhs  (b_nib),
        .same (nib_same)
    );

    nib_rank #(.SLICE(SLICE)) u_rank (
        .lhs       (a_nib),
        .rhs       (b_nib),
        .lhs_above (nib_above)
    );

    always_comb begin
        if (nib_same) begin
            to_high = from_low;
        end else begin
            to_high.gt = nib_above;
            to_high.eq = 1'b0;
            to_high.lt = ~nib_above;
        end
    end

    always_comb begin
        if (!$isunknown({a_nib, b_nib, from_low, to_high})) begin
            // R5 / R8: a differing nibble pair decides on its own
            p_local_decides_r5: assert ((a_nib == b_nib) ||
                (to_high == {a_nib > b_nib, 1'b0, a_nib < b_nib}))
                else $error("stage ignored local difference");
            // R6: equal nibbles pass the lower result through
            p_pass_through_r6: assert ((a_nib != b_nib) || (to_high == from_low))
                else $error("stage altered cascade value");
            // R4: one-hot in gives one-hot out
            p_one_hot_r4: assert (!$onehot(from_low) || $onehot(to_high))
                else $error("stage output not one-hot");
        end
    end
endmodule

// File: rtl/mag_cmp_chain.sv
module mag_cmp_chain
    import mag_cmp_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int SLICE = 4
) (
    input  logic [WIDTH-1:0] a_word,
    input  logic [WIDTH-1:0] b_word,
    input  logic             cin_gt,
    input  logic             cin_eq,
    input  logic             cin_lt,
    output logic             a_gt_b,
    output logic             a_eq_b,
    output logic             a_lt_b
);
    localparam int NSTAGE = WIDTH / SLICE;

    order_t link [NSTAGE+1];

    assign link[0] = '{gt: cin_gt, eq: cin_eq, lt: cin_lt};

    genvar si;
    generate
        for (si = 0; si < NSTAGE; si++) begin : g_stage
            cmp_stage #(.SLICE(SLICE)) u_stage (
                .a_nib    (a_word[si*SLICE +: SLICE]),
                .b_nib    (b_word[si*SLICE +: SLICE]),
                .from_low (link[si]),
                .to_high  (link[si+1])
            );
        end
    endgenerate

    assign a_gt_b = link[NSTAGE].gt;
    assign a_eq_b = link[NSTAGE].eq;
    assign a_lt_b = link[NSTAGE].lt;

    always_comb begin
        if (!$isunknown({a_word, b_word, cin_gt, cin_eq, cin_lt, a_gt_b, a_eq_b, a_lt_b})
            && {cin_gt, cin_eq, cin_lt} == 3'b010) begin
            // R1
            p_word_gt_r1: assert (a_gt_b == (a_word > b_word))
                else $error("word greater wrong");
            // R2
            p_word_eq_r2: assert (a_eq_b == (a_word == b_word))
                else $error("word equal wrong");
            // R3
            p_word_lt_r3: assert (a_lt_b == (a_word < b_word))
                else $error("word less wrong");
        end
    end
endmodule

// File: tb/mag_cmp_chain_bench.sv
module mag_cmp_chain_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 100000;

    typedef struct packed {
        logic [7:0] a;
        logic [7:0] b;
        logic [2:0] cin;
        logic [2:0] expect_o;
    } vec_t;

    localparam int NVEC = 18;
    localparam vec_t VECS [NVEC] = '{
        '{8'h35, 8'h35, 3'b010, 3'b010},
        '{8'h35, 8'h35, 3'b100, 3'b100},
        '{8'h35, 8'h35, 3'b001, 3'b001},
        '{8'h35, 8'h35, 3'b000, 3'b000},
        '{8'h35, 8'h35, 3'b111, 3'b111},
        '{8'h80, 8'h7F, 3'b010, 3'b100},
        '{8'h7F, 8'h80, 3'b010, 3'b001},
        '{8'h3A, 8'h25, 3'b001, 3'b100},
        '{8'h25, 8'h3A, 3'b100, 3'b001},
        '{8'h2A, 8'h35, 3'b010, 3'b001},
        '{8'h35, 8'h2A, 3'b111, 3'b100},
        '{8'h41, 8'h4F, 3'b100, 3'b001},
        '{8'h4F, 8'h41, 3'b001, 3'b100},
        '{8'h4F, 8'h41, 3'b000, 3'b100},
        '{8'h01, 8'h00, 3'b010, 3'b100},
        '{8'h00, 8'h01, 3'b010, 3'b001},
        '{8'hFF, 8'hFF, 3'b010, 3'b010},
        '{8'h00, 8'h00, 3'b010, 3'b010}
    };

    logic clk = 1'b0;
    logic [7:0] a_word, b_word;
    logic cin_gt, cin_eq, cin_lt;
    logic a_gt_b, a_eq_b, a_lt_b;
    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mag_cmp_chain u_mag_cmp_chain (
        .a_word (a_word),
        .b_word (b_word),
        .cin_gt (cin_gt),
        .cin_eq (cin_eq),
        .cin_lt (cin_lt),
        .a_gt_b (a_gt_b),
        .a_eq_b (a_eq_b),
        .a_lt_b (a_lt_b)
    );

    function automatic logic [2:0] model(input logic [7:0] a, input logic [7:0] b,
                                         input logic [2:0] c);
        if (a > b) return 3'b100;
        if (a < b) return 3'b001;
        return c;
    endfunction

    task automatic apply_check(input logic [7:0] a, input logic [7:0] b,
                               input logic [2:0] c, input logic [2:0] exp_o,
                               input string req);
        a_word = a;
        b_word = b;
        {cin_gt, cin_eq, cin_lt} = c;
        #2;
        n_checks++;
        if ({a_gt_b, a_eq_b, a_lt_b} !== exp_o) begin
            n_fail++;
            $display("FAIL %s: a=%h b=%h cin=%b actual=%b expected=%b",
                     req, a, b, c, {a_gt_b, a_eq_b, a_lt_b}, exp_o);
        end
    endtask

    initial begin
        a_word = '0;
        b_word = '0;
        {cin_gt, cin_eq, cin_lt} = 3'b010;
        @(posedge clk);
        #1;
        // start-up state: zero operands, normal cascade -> equal (R2)
        apply_check(8'h00, 8'h00, 3'b010, 3'b010, "R2 start");

        // directed table: R5, R6, R7, R8 and opposing nibble decisions
        for (int i = 0; i < NVEC; i++) begin
            apply_check(VECS[i].a, VECS[i].b, VECS[i].cin, VECS[i].expect_o,
                        "R5/R6/R7/R8 table");
        end

        // exhaustive sweep with normal cascade: R1 R2 R3
        for (int ia = 0; ia < 256; ia++) begin
            for (int ib = 0; ib < 256; ib++) begin
                apply_check(ia[7:0], ib[7:0], 3'b010,
                            model(ia[7:0], ib[7:0], 3'b010), "R1 R2 R3 sweep");
            end
        end

        // R4: every one-hot cascade pattern against a spread of operands
        for (int k = 0; k < 3; k++) begin
            for (int ia = 0; ia < 256; ia += 17) begin
                for (int ib = 0; ib < 256; ib += 13) begin
                    apply_check(ia[7:0], ib[7:0], 3'b001 << k,
                                model(ia[7:0], ib[7:0], 3'b001 << k), "R4 one-hot");
                end
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule